// File: doc/BRIEF.md
# Edge-Triggered Event Logger Mission Controller

This block runs the logging mission of a tamper-resistant event recorder. An asynchronous event line is synchronised, filtered against short glitches and checked for the chosen edge polarity. Once a mission is under way, each accepted event stores the number of elapsed time units since the previous event into a byte-wide log memory, two bytes per record with the low byte first. The elapsed counter advances only on strobes from the calendar (second, minute or hour), so a record's unit follows the selected resolution.

The host drives the block with configuration bits and one-cycle command notifications. Any command during a mission stops the mission once the record in flight is done. A mission starts either at the first event after arming or at once on a start command, and it may only start after a two-step wipe of the log and its counters. When the log fills, the block either takes a fresh timestamp and starts writing from the base again, or stops writing while it keeps counting events. An elapsed count that would reach all ones before an event arrives is written as a continuation record.

Top module: `evlog_mission`

## Requirements
- R1: `cfg_trig` selects the edges that count as events: 2'b01 falling, 2'b10 rising, 2'b11 both. With 2'b00 no event is seen and neither start command can begin a mission.
- R2: After the two-stage synchroniser, the event line must hold a new level for FILT (default 2) clock cycles before it is accepted. A level held for one cycle produces no event.
- R3: `cfg_ivl` picks the elapsed-count strobe: 2'b01 `sec_tick`, 2'b10 `min_tick`, 2'b11 `hr_tick`. Other strobes do not change `elapsed`. With 2'b00 no mission can start.
- R4: Start by arming (`cmd_op` 3'd2). `armed` rises and `mission` stays low. The first accepted event then raises `mission`, loads `stamp` from `now_stamp`, zeroes `ev0_elapsed`, sets `evt_count` to 1 and writes nothing to the log.
- R5: Start by command (`cmd_op` 3'd3). `mission` and `armed` rise at once, `stamp` takes `now_stamp` and `evt_count` becomes 1. The first event after that is logged as the time since the start.
- R6: Each event during a mission writes `elapsed` at byte `wr_ptr` (low byte) and `wr_ptr`+1 (high byte). It then advances `wr_ptr` by 2, increments `evt_count` and clears `elapsed`.
- R7: A strobe that would take `elapsed` to 16'hFFFF writes FFh,FFh to the log as a continuation record. It advances `wr_ptr` by 2 and restarts `elapsed` from 0. `evt_count` is unchanged.
- R8: When the log is full and `cfg_wrap` is 1, the next event sets `rof`, loads `stamp` from `now_stamp`, puts `elapsed` into `ev0_elapsed`, counts the event and leaves `wr_ptr` at 0. Later events log from address 0 again.
- R9: When `cfg_wrap` is 0, the write that fills the log sets `rof`. Later events are counted but never written.
- R10: A wipe needs `cmd_op` 3'd0 (clear enable) followed directly by 3'd1 (clear) while `cfg_clr_ok` is 1. Any other command in between drops `clr_en`. A wipe zeroes the log, `evt_count`, `stamp`, `ev0_elapsed`, `wr_ptr` and `rof`, then sets `mem_clr` and drops `clr_en`.
- R11: Both start commands are ignored while `mem_clr` is 0, and `mem_clr` is 0 after reset. A mission start clears `mem_clr`.
- R12: Any command during a mission stops it after the record in progress. `mission` and `armed` fall, and the log and counters are kept.
- R13: `rd_data` returns the log byte at `rd_addr` one cycle later, and returns 0 while a mission or a wipe runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_in | input | 1 | Asynchronous event line |
| sec_tick | input | 1 | Calendar seconds strobe |
| min_tick | input | 1 | Calendar minutes strobe |
| hr_tick | input | 1 | Calendar hours strobe |
| now_stamp | input | SW | Current calendar value |
| cfg_trig | input | 2 | Edge select |
| cfg_ivl | input | 2 | Elapsed-unit select |
| cfg_wrap | input | 1 | 1: restart log when full; 0: stop writing |
| cfg_clr_ok | input | 1 | Wipe permitted |
| cmd_valid | input | 1 | Host register write notification |
| cmd_op | input | 3 | 0 clear enable, 1 clear, 2 arm, 3 start, others: plain write |
| rd_addr | input | AW | Host log read address |
| rd_data | output | 8 | Host log read data |
| mission | output | 1 | Mission running |
| armed | output | 1 | Mission enabled |
| clr_en | output | 1 | Clear enable pending |
| mem_clr | output | 1 | Log and counters wiped |
| rof | output | 1 | Log filled at least once |
| evt_count | output | CW | Events in this mission |
| wr_ptr | output | AW | Next log write address |
| elapsed | output | 16 | Elapsed-unit counter |
| stamp | output | SW | Start timestamp |
| ev0_elapsed | output | 16 | Elapsed count carried across a restart |

## Verification
The hardest states to reach are the log-full conditions and the continuation record. Filling the 2048-byte log takes 1024 separate filtered events, and the continuation record needs 65535 unit strobes with no event between them. The bench holds `sec_tick` high for exactly 65535 cycles and then checks both bytes of the record. It uses both-edge triggering so each level change is one event, and toggles the line 1024 times in each of the two wrap modes before it sends the event that crosses the boundary.

// File: rtl/evlog_pkg.sv
package evlog_pkg;
  localparam int EW = 16;  // elapsed counter width: two log bytes per record

  typedef enum logic [2:0] {
    OP_CLR_EN = 3'd0,
    OP_CLEAR  = 3'd1,
    OP_ARM    = 3'd2,
    OP_GO     = 3'd3,
    OP_OTHER  = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LO,
    ST_HI,
    ST_WIPE
  } st_e;
endpackage

// File: rtl/evlog_edge.sv
module evlog_edge #(
  parameter int SYNC = 2,
  parameter int FILT = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       evt_in,
  input  logic [1:0] trig,
  output logic       ev_o
);
  localparam int FW = $clog2(FILT + 1);

  logic [SYNC-1:0] sync_q;
  logic            s;
  logic            filt_q;
  logic [FW-1:0]   cnt_q;

  generate
    if (SYNC == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= evt_in;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC-2:0], evt_in};
      end
    end
  endgenerate

  assign s = sync_q[SYNC-1];

  // new level must persist FILT cycles; the line idles low
  always_ff @(posedge clk) begin
    if (rst) begin
      filt_q <= 1'b0;
      cnt_q  <= '0;
      ev_o   <= 1'b0;
    end else begin
      ev_o <= 1'b0;
      if (s != filt_q) begin
        if (cnt_q == FW'(FILT - 1)) begin
          filt_q <= s;
          cnt_q  <= '0;
          ev_o   <= s ? trig[1] : trig[0];
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end
endmodule

// File: rtl/evlog_elapsed.sv
module evlog_elapsed
  import evlog_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          clr,
  input  logic [1:0]    ivl,
  input  logic          sec_t,
  input  logic          min_t,
  input  logic          hr_t,
  output logic [EW-1:0] cnt_o,
  output logic          mark_o
);
  localparam logic [EW-1:0] NEAR_TOP = {{(EW-1){1'b1}}, 1'b0};

  logic tick;

  always_comb begin
    unique case (ivl)
      2'b01:   tick = sec_t;
      2'b10:   tick = min_t;
      2'b11:   tick = hr_t;
      default: tick = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o  <= '0;
      mark_o <= 1'b0;
    end else begin
      mark_o <= 1'b0;
      if (clr) begin
        cnt_o <= '0;
      end else if (run && tick) begin
        if (cnt_o == NEAR_TOP) begin
          cnt_o  <= '0;
          mark_o <= 1'b1;
        end else begin
          cnt_o <= cnt_o + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/evlog_ram.sv
module evlog_ram #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wd,
  output logic [DW-1:0] rq
);
  logic [DW-1:0] mem [2**AW];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wd;
    rq <= mem[addr];
  end
endmodule

// File: rtl/evlog_mission.sv
module evlog_mission
  import evlog_pkg::*;
#(
  parameter int LOG_BYTES = 2048,
  parameter int CW        = 24,
  parameter int SW        = 64,
  parameter int FILT      = 2,
  localparam int AW       = $clog2(LOG_BYTES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          evt_in,
  input  logic          sec_tick,
  input  logic          min_tick,
  input  logic          hr_tick,
  input  logic [SW-1:0] now_stamp,
  input  logic [1:0]    cfg_trig,
  input  logic [1:0]    cfg_ivl,
  input  logic          cfg_wrap,
  input  logic          cfg_clr_ok,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic          mission,
  output logic          armed,
  output logic          clr_en,
  output logic          mem_clr,
  output logic          rof,
  output logic [CW-1:0] evt_count,
  output logic [AW-1:0] wr_ptr,
  output logic [EW-1:0] elapsed,
  output logic [SW-1:0] stamp,
  output logic [EW-1:0] ev0_elapsed
);
  localparam logic [AW-1:0] LAST = AW'(LOG_BYTES - 1);

  st_e           st;
  logic          ev, el_mark, el_clr;
  logic          mark_pend, stop_req, full, blk_q;
  logic [EW-1:0] wdata;
  logic          cfg_ok, can_start, idle;
  logic          go_start, ev_start, ev_take, mark_take, wipe_start;
  logic          ram_we;
  logic [AW-1:0] ram_addr;
  logic [7:0]    ram_wd, ram_q;

  evlog_edge #(.SYNC(2), .FILT(FILT)) u_edge (
    .clk(clk), .rst(rst), .evt_in(evt_in), .trig(cfg_trig), .ev_o(ev)
  );

  evlog_elapsed u_el (
    .clk(clk), .rst(rst), .run(mission), .clr(el_clr), .ivl(cfg_ivl),
    .sec_t(sec_tick), .min_t(min_tick), .hr_t(hr_tick),
    .cnt_o(elapsed), .mark_o(el_mark)
  );

  evlog_ram #(.AW(AW), .DW(8)) u_ram (
    .clk(clk), .we(ram_we), .addr(ram_addr), .wd(ram_wd), .rq(ram_q)
  );

  always_comb begin
    idle       = (st == ST_IDLE);
    cfg_ok     = (cfg_trig != 2'b00) && (cfg_ivl != 2'b00);
    can_start  = mem_clr && cfg_ok && !mission;
    go_start   = idle && cmd_valid && (cmd_op == OP_GO) && can_start;
    ev_start   = idle && ev && armed && !mission && cfg_ok;
    mark_take  = idle && mark_pend && mission && !stop_req;
    ev_take    = idle && ev && mission && !stop_req && !mark_pend;
    el_clr     = go_start || ev_start || ev_take;
    wipe_start = idle && cmd_valid && (cmd_op == OP_CLEAR) && clr_en &&
                 cfg_clr_ok && !mission && !armed;
    ram_we     = (st != ST_IDLE);
    ram_addr   = ram_we ? wr_ptr : rd_addr;
    unique case (st)
      ST_LO:   ram_wd = wdata[7:0];
      ST_HI:   ram_wd = wdata[15:8];
      default: ram_wd = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) blk_q <= 1'b0;
    else     blk_q <= mission || (st == ST_WIPE);
  end
  assign rd_data = blk_q ? 8'h00 : ram_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      mission     <= 1'b0;
      armed       <= 1'b0;
      clr_en      <= 1'b0;
      mem_clr     <= 1'b0;
      rof         <= 1'b0;
      full        <= 1'b0;
      mark_pend   <= 1'b0;
      stop_req    <= 1'b0;
      evt_count   <= '0;
      wr_ptr      <= '0;
      stamp       <= '0;
      ev0_elapsed <= '0;
      wdata       <= '0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (stop_req) begin
            mission   <= 1'b0;
            armed     <= 1'b0;
            stop_req  <= 1'b0;
            mark_pend <= 1'b0;
          end else if (mark_take) begin
            mark_pend <= 1'b0;
            wdata     <= {EW{1'b1}};
            if (!full) st <= ST_LO;
          end else if (ev_start) begin
            mission     <= 1'b1;
            stamp       <= now_stamp;
            ev0_elapsed <= '0;
            evt_count   <= CW'(1);
            mem_clr     <= 1'b0;
            clr_en      <= 1'b0;
          end else if (ev_take) begin
            evt_count <= evt_count + 1'b1;
            if (!full) begin
              wdata <= elapsed;
              st    <= ST_LO;
            end else if (cfg_wrap) begin
              stamp       <= now_stamp;
              ev0_elapsed <= elapsed;
              full        <= 1'b0;
              rof         <= 1'b1;
            end
          end
        end
        ST_LO: begin
          wr_ptr <= wr_ptr + 1'b1;
          st     <= ST_HI;
        end
        ST_HI: begin
          wr_ptr <= wr_ptr + 1'b1;
          st     <= ST_IDLE;
          if (wr_ptr == LAST) begin
            full <= 1'b1;
            if (!cfg_wrap) rof <= 1'b1;
          end
        end
        ST_WIPE: begin
          wr_ptr <= wr_ptr + 1'b1;
          if (wr_ptr == LAST) begin
            st          <= ST_IDLE;
            evt_count   <= '0;
            stamp       <= '0;
            ev0_elapsed <= '0;
            rof         <= 1'b0;
            full        <= 1'b0;
            mark_pend   <= 1'b0;
            mem_clr     <= 1'b1;
            clr_en      <= 1'b0;
          end
        end
        default: st <= ST_IDLE;
      endcase

      if (el_mark) mark_pend <= 1'b1;

      if (cmd_valid && st != ST_WIPE) begin
        if (mission) begin
          stop_req <= 1'b1;
          clr_en   <= 1'b0;
        end else begin
          unique case (op_e'(cmd_op))
            OP_CLR_EN: clr_en <= !ev_start;
            OP_CLEAR: begin
              clr_en <= 1'b0;
              if (wipe_start) begin
                st     <= ST_WIPE;
                wr_ptr <= '0;
              end
            end
            OP_ARM: begin
              clr_en <= 1'b0;
              if (can_start) armed <= 1'b1;
            end
            OP_GO: begin
              clr_en <= 1'b0;
              if (go_start) begin
                armed       <= 1'b1;
                mission     <= 1'b1;
                stamp       <= now_stamp;
                ev0_elapsed <= '0;
                evt_count   <= CW'(1);
                mem_clr     <= 1'b0;
              end
            end
            default: clr_en <= 1'b0;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/evlog_mission_chk.sv
module evlog_mission_chk #(
  parameter int AW = 11,
  parameter int CW = 24
) (
  input logic          clk,
  input logic          rst,
  input logic          mission,
  input logic          armed,
  input logic          mem_clr,
  input logic          clr_en,
  input logic          rof,
  input logic [CW-1:0] evt_count,
  input logic [AW-1:0] wr_ptr,
  input logic [7:0]    rd_data,
  input logic [1:0]    cfg_trig,
  input logic [1:0]    cfg_ivl
);
  // R4: a running mission is always an enabled one
  p_mission_armed_r4: assert property (@(posedge clk) disable iff (rst)
    mission |-> armed);

  // R11: wiped state and running mission are exclusive
  p_memclr_idle_r11: assert property (@(posedge clk) disable iff (rst)
    mission |-> !mem_clr);

  // R1: no start unless the edge select was legal
  p_start_trig_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(mission) |-> $past(cfg_trig) != 2'b00);

  // R3: no start unless the unit select was legal
  p_start_ivl_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(mission) |-> $past(cfg_ivl) != 2'b00);

  // R6: during a mission the event count moves by at most one per cycle
  p_count_step_r6: assert property (@(posedge clk) disable iff (rst)
    mission && $past(mission) |->
      (evt_count == $past(evt_count)) || (evt_count == $past(evt_count) + 1'b1));

  // R6: the write pointer moves by at most one byte per cycle in a mission
  p_ptr_step_r6: assert property (@(posedge clk) disable iff (rst)
    mission && $past(mission) |->
      (wr_ptr == $past(wr_ptr)) || (wr_ptr == $past(wr_ptr) + 1'b1));

  // R8: the rollover flag only falls through a wipe
  p_rof_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    rof |=> rof || mem_clr);

  // R10: no clear enable survives into a mission
  p_clr_en_off_r10: assert property (@(posedge clk) disable iff (rst)
    mission |-> !clr_en);

  // R13: reads are blocked while a mission runs
  p_read_block_r13: assert property (@(posedge clk) disable iff (rst)
    mission |=> rd_data == 8'h00);
endmodule

bind evlog_mission evlog_mission_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .mission(mission), .armed(armed), .mem_clr(mem_clr),
  .clr_en(clr_en), .rof(rof), .evt_count(evt_count), .wr_ptr(wr_ptr),
  .rd_data(rd_data), .cfg_trig(cfg_trig), .cfg_ivl(cfg_ivl)
);

// File: tb/sim_evlog_mission.sv
`timescale 1ns/1ps
module sim_evlog_mission;
  import evlog_pkg::*;

  localparam int AW = 11;
  localparam int CW = 24;
  localparam int SW = 64;
  localparam int NREC = 1024;

  // [11:10] edge select, [8] glitch-only stimulus, [7:0] expected event count
  localparam logic [11:0] VEC [4] = '{12'h402, 12'h802, 12'hC03, 12'hD01};

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          evt_in = 1'b0;
  logic          sec_tick = 1'b0, min_tick = 1'b0, hr_tick = 1'b0;
  logic [SW-1:0] now_stamp = '0;
  logic [1:0]    cfg_trig = 2'b10, cfg_ivl = 2'b01;
  logic          cfg_wrap = 1'b0, cfg_clr_ok = 1'b1;
  logic          cmd_valid = 1'b0;
  logic [2:0]    cmd_op = 3'd4;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0]    rd_data;
  logic          mission, armed, clr_en, mem_clr, rof;
  logic [CW-1:0] evt_count;
  logic [AW-1:0] wr_ptr;
  logic [15:0]   elapsed, ev0_elapsed;
  logic [SW-1:0] stamp;

  int nchk = 0;
  int nfail = 0;

  always #2.5 clk = ~clk;

  evlog_mission u0 (
    .clk(clk), .rst(rst), .evt_in(evt_in), .sec_tick(sec_tick),
    .min_tick(min_tick), .hr_tick(hr_tick), .now_stamp(now_stamp),
    .cfg_trig(cfg_trig), .cfg_ivl(cfg_ivl), .cfg_wrap(cfg_wrap),
    .cfg_clr_ok(cfg_clr_ok), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .rd_addr(rd_addr), .rd_data(rd_data), .mission(mission), .armed(armed),
    .clr_en(clr_en), .mem_clr(mem_clr), .rof(rof), .evt_count(evt_count),
    .wr_ptr(wr_ptr), .elapsed(elapsed), .stamp(stamp),
    .ev0_elapsed(ev0_elapsed)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cmd(input logic [2:0] op);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op = op;
    @(negedge clk);
    cmd_valid = 1'b0;
    wait_n(3);
  endtask

  task automatic do_clear();
    cmd(OP_CLR_EN);
    cmd(OP_CLEAR);
    wait_n(2**AW + 8);
  endtask

  task automatic level(input logic v);
    evt_in = v;
    wait_n(12);
  endtask

  task automatic strobe(input int which, input int n);
    for (int k = 0; k < n; k++) begin
      if (which == 0) sec_tick = 1'b1;
      else if (which == 1) min_tick = 1'b1;
      else hr_tick = 1'b1;
      @(negedge clk);
      sec_tick = 1'b0; min_tick = 1'b0; hr_tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
    rd_addr = a;
    wait_n(2);
    d = rd_data;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired: actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [7:0] b;
    wait_n(4);
    rst = 1'b0;
    wait_n(2);

    // reset state; start refused before any wipe (R11)
    check("R11 reset mission", mission, 0);
    check("R11 reset mem_clr", mem_clr, 0);
    check("R12 reset armed", armed, 0);
    check("R6 reset count", evt_count, 0);
    check("R6 reset ptr", wr_ptr, 0);
    cmd(OP_GO);
    check("R11 start without wipe", mission, 0);

    // edge-select and glitch vectors (R1, R2)
    for (int i = 0; i < 4; i++) begin
      logic [11:0] v;
      v = VEC[i];
      do_clear();
      cfg_trig = v[11:10];
      cfg_ivl = 2'b01;
      cmd(OP_GO);
      if (v[8]) begin
        evt_in = 1'b1; wait_n(1); evt_in = 1'b0; wait_n(10);
        evt_in = 1'b1; wait_n(1); evt_in = 1'b0; wait_n(10);
        check("R2 glitch ignored", evt_count, {16'd0, v[7:0]});
      end else begin
        level(1'b1);
        level(1'b0);
        check("R1 edge select count", evt_count, {16'd0, v[7:0]});
      end
      cmd(OP_OTHER);
    end

    // illegal selects block start (R1, R3)
    do_clear();
    cfg_trig = 2'b11; cfg_ivl = 2'b00;
    cmd(OP_GO);
    check("R3 unit 00 blocks start", mission, 0);
    cfg_trig = 2'b00; cfg_ivl = 2'b01;
    cmd(OP_GO);
    check("R1 edge 00 blocks start", mission, 0);

    // command start, unit select, logging, blocked read (R5, R3, R6, R13)
    cfg_trig = 2'b10;
    now_stamp = 64'h1234;
    cmd(OP_GO);
    check("R5 start mission", mission, 1);
    check("R5 start stamp", stamp, 64'h1234);
    check("R5 start count", evt_count, 1);
    strobe(1, 3);
    strobe(2, 2);
    strobe(0, 5);
    check("R3 only seconds counted", elapsed, 5);
    rd(0, b);
    check("R13 read blocked in mission", b, 0);
    level(1'b1);
    check("R6 count after event", evt_count, 2);
    check("R6 ptr after event", wr_ptr, 2);
    check("R6 elapsed cleared", elapsed, 0);
    strobe(0, 3);
    level(1'b0);
    level(1'b1);
    check("R6 second record ptr", wr_ptr, 4);
    check("R6 second record count", evt_count, 3);
    cmd(OP_OTHER);
    check("R12 stopped mission", mission, 0);
    check("R12 stopped armed", armed, 0);
    check("R12 count kept", evt_count, 3);
    rd(0, b); check("R6 R13 byte 0", b, 8'h05);
    rd(1, b); check("R6 R13 byte 1", b, 8'h00);
    rd(2, b); check("R6 R13 byte 2", b, 8'h03);
    cmd(OP_ARM);
    check("R11 arm without wipe", armed, 0);

    // two-step wipe (R10)
    cmd(OP_CLR_EN); cmd(OP_OTHER); cmd(OP_CLEAR);
    wait_n(2**AW + 8);
    check("R10 interrupted wipe", mem_clr, 0);
    check("R10 interrupted keeps count", evt_count, 3);
    cfg_clr_ok = 1'b0;
    cmd(OP_CLR_EN); cmd(OP_CLEAR);
    wait_n(2**AW + 8);
    check("R10 wipe not permitted", mem_clr, 0);
    cfg_clr_ok = 1'b1;
    do_clear();
    check("R10 wipe done", mem_clr, 1);
    check("R10 wipe count", evt_count, 0);
    check("R10 wipe stamp", stamp, 0);
    check("R10 wipe clr_en", clr_en, 0);
    rd(0, b); check("R10 wipe log byte", b, 0);

    // arm start (R4)
    evt_in = 1'b0;
    cmd(OP_ARM);
    check("R4 armed", armed, 1);
    check("R4 not yet running", mission, 0);
    now_stamp = 64'h55;
    level(1'b1);
    check("R4 running", mission, 1);
    check("R4 stamp", stamp, 64'h55);
    check("R4 count", evt_count, 1);
    check("R4 nothing logged", wr_ptr, 0);
    check("R11 mem_clr dropped", mem_clr, 0);
    cmd(OP_OTHER);
    evt_in = 1'b0;
    wait_n(12);

    // continuation record (R7)
    do_clear();
    cmd(OP_GO);
    sec_tick = 1'b1;
    wait_n(65535);
    sec_tick = 1'b0;
    wait_n(8);
    check("R7 marker ptr", wr_ptr, 2);
    check("R7 marker count", evt_count, 1);
    check("R7 elapsed restarted", elapsed, 0);
    cmd(OP_OTHER);
    rd(0, b); check("R7 marker low", b, 8'hFF);
    rd(1, b); check("R7 marker high", b, 8'hFF);

    // full log, restart mode (R8)
    do_clear();
    cfg_trig = 2'b11; cfg_wrap = 1'b1;
    cmd(OP_GO);
    for (int k = 0; k < NREC; k++) level(~evt_in);
    check("R8 full ptr", wr_ptr, 0);
    check("R8 no flag yet", rof, 0);
    check("R8 full count", evt_count, NREC + 1);
    strobe(0, 2);
    now_stamp = 64'h77;
    level(~evt_in);
    check("R8 flag", rof, 1);
    check("R8 new stamp", stamp, 64'h77);
    check("R8 carried elapsed", ev0_elapsed, 2);
    check("R8 ptr at base", wr_ptr, 0);
    level(~evt_in);
    check("R8 relog ptr", wr_ptr, 2);
    check("R8 relog count", evt_count, NREC + 3);
    cmd(OP_OTHER);

    // full log, stop-writing mode (R9)
    evt_in = 1'b0; wait_n(12);
    do_clear();
    cfg_wrap = 1'b0;
    cmd(OP_GO);
    for (int k = 0; k < NREC; k++) level(~evt_in);
    check("R9 flag on fill", rof, 1);
    check("R9 full count", evt_count, NREC + 1);
    strobe(0, 3);
    level(~evt_in);
    check("R9 still counted", evt_count, NREC + 2);
    check("R9 no write ptr", wr_ptr, 0);
    cmd(OP_OTHER);
    rd(0, b); check("R9 byte 0 untouched", b, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule